// File: doc/BRIEF.md
# Interrupt Source Sensing and Pending Logic

This block turns up to 32 raw interrupt inputs into per-source pending flags. Every input is first brought into the block's clock domain through a chain of flip-flops. It is then judged against that source's sensitivity: high level, low level, rising edge or falling edge. A level-sensitive flag follows its input. An edge-sensitive flag is latched and held until the priority controller sends a one-cycle acknowledge pulse for that source.

Sources at indices from `EXT_FIRST` upward are external pins and can use all four sensitivities. Sources below that index belong to internal peripherals and only offer high level or rising edge. The enable mask is kept by two single-write strobes, one that sets bits and one that clears them, so software never needs a read-modify-write. The block presents three vectors: the raw pending flags, the pending flags gated by the mask, and the mask itself. The priority controller consumes the gated vector.

Top module: `irq_sense_top`

## Requirements
- R1: After reset, `pend_raw`, `pend_active` and `mask_rd` are all zero, and every source is in high-level mode.
- R2: In high-level mode, `pend_raw[i]` equals the value `irq_in[i]` had three rising clock edges earlier: two synchroniser stages, then the pending register.
- R3: `cfg_mode` encodes sensitivity as follows: bit 1 selects edge (1) or level (0), and bit 0 selects active-low or falling (1) or active-high or rising (0). On an external source, code 01 gives low level and code 11 gives falling edge.
- R4: A cycle with `en_set_we` high sets every mask bit where `en_set_data` is 1 and leaves the other bits unchanged. The new mask is visible on `mask_rd` after that clock edge.
- R5: A cycle with `en_clr_we` high clears every mask bit where `en_clr_data` is 1. If one bit is both set and cleared in the same cycle, it ends up cleared.
- R6: On an internal source (index below `EXT_FIRST`), bit 0 of the mode is ignored, so code 01 acts as high level and code 11 acts as rising edge.
- R7: In edge mode, a detected edge sets the pending flag, and the flag stays set after the input returns to its idle value.
- R8: An `ack_clr[i]` pulse clears an edge-mode pending flag at the next clock edge. It has no effect on a level-mode flag.
- R9: If a new edge is detected in the same cycle as `ack_clr[i]`, the flag stays set.
- R10: A configuration write to a source clears its pending flag. A change of polarity alone never creates an edge.
- R11: `pend_active` equals `pend_raw` ANDed with the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Raw asynchronous interrupt inputs |
| cfg_we | input | 1 | Sensitivity write strobe |
| cfg_idx | input | IDX_W | Source index of the sensitivity write |
| cfg_mode | input | 2 | Sensitivity code (see R3) |
| en_set_we | input | 1 | Mask set strobe |
| en_set_data | input | NUM_SRC | Bits to set in the mask |
| en_clr_we | input | 1 | Mask clear strobe |
| en_clr_data | input | NUM_SRC | Bits to clear in the mask |
| ack_clr | input | NUM_SRC | Per-source acknowledge pulses from the priority controller |
| pend_raw | output | NUM_SRC | Pending flags before masking |
| pend_active | output | NUM_SRC | Pending flags gated by the mask |
| mask_rd | output | NUM_SRC | Current enable mask |

## Verification
A corrupted mask bit appears on `mask_rd` and `pend_active` one edge after the write that caused it. If a sticky flag is lost or a clear arrives too early, `pend_raw` drops while the input is idle; this shows within one cycle of the acknowledge, or within three cycles of the input change. A wrong polarity or mode bit inverts the flag three edges after the input moves, and a false edge from a mode write shows on the very next edge. The hardest case is an edge that coincides with an acknowledge, so it is driven with exact cycle alignment.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

  typedef enum logic [1:0] {
    SNS_LVL_HI = 2'b00,
    SNS_LVL_LO = 2'b01,
    SNS_RISE   = 2'b10,
    SNS_FALL   = 2'b11
  } sns_mode_e;

  // Internal sources keep only the edge/level choice; polarity is forced active-high.
  function automatic logic [1:0] sns_effective(input logic [1:0] req, input logic is_ext);
    return {req[1], req[0] & is_ext};
  endfunction

  // Edge detection on the unnormalised synchronised value.
  function automatic logic sns_edge_seen(input logic cur, input logic prev, input logic fall);
    return fall ? (~cur & prev) : (cur & ~prev);
  endfunction

  // Next pending value: a wipe has top priority, then a new edge beats the acknowledge.
  function automatic logic sns_pend_next(input logic is_edge, input logic norm,
                                         input logic cur, input logic hit,
                                         input logic ack, input logic wipe);
    if (wipe)         return 1'b0;
    else if (is_edge) return hit | (cur & ~ack);
    else              return norm;
  endfunction

endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[k] <= '0;
          else        stg[k] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) stg[k] <= '0;
          else        stg[k] <= stg[k-1];
        end
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_sense_pkg::*;
#(
  parameter bit IS_EXT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic       wr,
  input  logic [1:0] wr_mode,
  input  logic       ack,
  output logic       pend,
  output logic       hit,
  output logic       norm,
  output logic       is_edge
);
  logic [1:0] mode_q;
  logic       prev_q;

  assign is_edge = mode_q[1];
  assign norm    = sync_in ^ mode_q[0];
  assign hit     = is_edge & sns_edge_seen(sync_in, prev_q, mode_q[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= SNS_LVL_HI;
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= sync_in;
      pend   <= sns_pend_next(is_edge, norm, pend, hit, ack, wr);
      if (wr) mode_q <= sns_effective(wr_mode, IS_EXT);
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic [WIDTH-1:0] set_data,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] clr_data,
  output logic [WIDTH-1:0] mask
);
  logic [WIDTH-1:0] set_bits, clr_bits;

  assign set_bits = set_we ? set_data : '0;
  assign clr_bits = clr_we ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else        mask <= (mask | set_bits) & ~clr_bits;
  end
endmodule

// File: rtl/irq_sense_top.sv
module irq_sense_top #(
  parameter int NUM_SRC     = 32,
  parameter int EXT_FIRST   = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [1:0]         cfg_mode,
  input  logic               en_set_we,
  input  logic [NUM_SRC-1:0] en_set_data,
  input  logic               en_clr_we,
  input  logic [NUM_SRC-1:0] en_clr_data,
  input  logic [NUM_SRC-1:0] ack_clr,
  output logic [NUM_SRC-1:0] pend_raw,
  output logic [NUM_SRC-1:0] pend_active,
  output logic [NUM_SRC-1:0] mask_rd
);
  logic [NUM_SRC-1:0] sync_vec;
  logic [NUM_SRC-1:0] wipe_vec;
  logic [NUM_SRC-1:0] hit_vec;
  logic [NUM_SRC-1:0] norm_vec;
  logic [NUM_SRC-1:0] edge_vec;

  irq_sync_bank #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_async(irq_in), .q_sync(sync_vec)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign wipe_vec[i] = cfg_we && (cfg_idx == IDX_W'(i));
      irq_src_cell #(.IS_EXT(i >= EXT_FIRST)) cell_i (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_vec[i]),
        .wr(wipe_vec[i]), .wr_mode(cfg_mode), .ack(ack_clr[i]),
        .pend(pend_raw[i]), .hit(hit_vec[i]), .norm(norm_vec[i]),
        .is_edge(edge_vec[i])
      );
    end
  endgenerate

  irq_mask_reg #(.WIDTH(NUM_SRC)) mask_i (
    .clk(clk), .rst_n(rst_n),
    .set_we(en_set_we), .set_data(en_set_data),
    .clr_we(en_clr_we), .clr_data(en_clr_data),
    .mask(mask_rd)
  );

  assign pend_active = pend_raw & mask_rd;
endmodule

// File: rtl/irq_sense_chk.sv
module irq_sense_chk #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en_set_we,
  input logic [NUM_SRC-1:0] en_set_data,
  input logic               en_clr_we,
  input logic [NUM_SRC-1:0] en_clr_data,
  input logic [NUM_SRC-1:0] ack_clr,
  input logic [NUM_SRC-1:0] pend_raw,
  input logic [NUM_SRC-1:0] mask_rd,
  input logic [NUM_SRC-1:0] wipe_vec,
  input logic [NUM_SRC-1:0] hit_vec,
  input logic [NUM_SRC-1:0] norm_vec,
  input logic [NUM_SRC-1:0] edge_vec
);
  logic [NUM_SRC-1:0] set_only, clr_bits, hold_vec, ack_quiet, ack_race;

  assign clr_bits  = en_clr_we ? en_clr_data : '0;
  assign set_only  = (en_set_we ? en_set_data : '0) & ~clr_bits;
  assign hold_vec  = edge_vec & pend_raw & ~ack_clr & ~wipe_vec;
  assign ack_quiet = edge_vec & ack_clr & ~hit_vec & ~wipe_vec;
  assign ack_race  = edge_vec & ack_clr & hit_vec & ~wipe_vec;

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask_rd & $past(set_only)) == $past(set_only)));

  // R5
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask_rd & $past(clr_bits)) == '0));

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_set_we && !en_clr_we) |=> $stable(mask_rd));

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend_raw ^ $past(norm_vec)) & ~$past(edge_vec) & ~$past(wipe_vec)) == '0));

  // R7
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_raw & $past(hold_vec)) == $past(hold_vec)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_raw & $past(ack_quiet)) == '0));

  // R9
  ack_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_raw & $past(ack_race)) == $past(ack_race)));

  // R10
  wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_raw & $past(wipe_vec)) == '0));
endmodule

bind irq_sense_top irq_sense_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .en_set_we(en_set_we), .en_set_data(en_set_data),
  .en_clr_we(en_clr_we), .en_clr_data(en_clr_data),
  .ack_clr(ack_clr), .pend_raw(pend_raw), .mask_rd(mask_rd),
  .wipe_vec(wipe_vec), .hit_vec(hit_vec), .norm_vec(norm_vec),
  .edge_vec(edge_vec)
);

// File: tb/irq_sense_top_tb_top.sv
module irq_sense_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_in = '0;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_idx = '0;
  logic [1:0]    cfg_mode = '0;
  logic          en_set_we = 1'b0;
  logic [NS-1:0] en_set_data = '0;
  logic          en_clr_we = 1'b0;
  logic [NS-1:0] en_clr_data = '0;
  logic [NS-1:0] ack_clr = '0;
  logic [NS-1:0] pend_raw, pend_active, mask_rd;

  irq_sense_top dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mode(cfg_mode),
    .en_set_we(en_set_we), .en_set_data(en_set_data),
    .en_clr_we(en_clr_we), .en_clr_data(en_clr_data),
    .ack_clr(ack_clr), .pend_raw(pend_raw),
    .pend_active(pend_active), .mask_rd(mask_rd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          sel;
    logic [NS-1:0] bits;
    logic [NS-1:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  item_t cur;
  logic [NS-1:0] act;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      cur = q.pop_front();
      act = (cur.sel == 0) ? pend_raw : (cur.sel == 1) ? pend_active : mask_rd;
      total++;
      if ((act & cur.bits) !== cur.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", cur.tag, act & cur.bits, cur.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_item(input int sel, input logic [NS-1:0] bits,
                             input logic [NS-1:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.bits = bits; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cfg(input int idx, input logic [1:0] m);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_mode = m;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic ack(input int idx);
    ack_clr[idx] = 1'b1;
    tick(1);
    ack_clr[idx] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    expect_item(0, '1, '0, "R1 pend_raw");
    expect_item(1, '1, '0, "R1 pend_active");
    expect_item(2, '1, '0, "R1 mask_rd");
    tick(1);

    // R2 level-high default; mask still zero so active gated (R11)
    irq_in[3] = 1'b1;
    tick(2);
    expect_item(0, 32'h8, 32'h0, "R2 not yet after two edges");
    tick(1);
    expect_item(0, 32'h8, 32'h8, "R2 level high after three edges");
    expect_item(1, 32'h8, 32'h0, "R11 masked");

    // R4 set strobe
    en_set_we = 1'b1; en_set_data = 32'h28;
    tick(1);
    en_set_we = 1'b0;
    expect_item(2, '1, 32'h28, "R4 set");
    expect_item(1, '1, 32'h08, "R11 active gated");
    en_set_we = 1'b1; en_set_data = 32'h80;
    tick(1);
    en_set_we = 1'b0;
    expect_item(2, '1, 32'hA8, "R4 zeros no effect");

    // R5 clear strobe, then set and clear collision
    en_clr_we = 1'b1; en_clr_data = 32'h20;
    tick(1);
    en_clr_we = 1'b0;
    expect_item(2, '1, 32'h88, "R5 clear");
    en_set_we = 1'b1; en_set_data = 32'h101;
    en_clr_we = 1'b1; en_clr_data = 32'h100;
    tick(1);
    en_set_we = 1'b0; en_clr_we = 1'b0;
    expect_item(2, '1, 32'h89, "R5 clear wins");

    // R8 ack has no effect on level source
    ack(3);
    expect_item(0, 32'h8, 32'h8, "R8 level ignores ack");

    // R2 level drops
    irq_in[3] = 1'b0;
    tick(3);
    expect_item(0, 32'h8, 32'h0, "R2 level released");

    // R3 level-low on external source 20
    cfg(20, 2'b01);
    tick(3);
    expect_item(0, 32'h0010_0000, 32'h0010_0000, "R3 level low idle");
    irq_in[20] = 1'b1;
    tick(3);
    expect_item(0, 32'h0010_0000, 32'h0, "R3 level low released");

    // R6 internal source 4 with code 01 acts as level high
    cfg(4, 2'b01);
    tick(3);
    expect_item(0, 32'h10, 32'h0, "R6 internal ignores low");
    irq_in[4] = 1'b1;
    tick(3);
    expect_item(0, 32'h10, 32'h10, "R6 internal high level");
    irq_in[4] = 1'b0;

    // R7 rising edge sticky on internal source 6
    cfg(6, 2'b10);
    irq_in[6] = 1'b1;
    tick(1);
    irq_in[6] = 1'b0;
    tick(4);
    expect_item(0, 32'h40, 32'h40, "R7 edge sticky");
    ack(6);
    expect_item(0, 32'h40, 32'h0, "R8 ack clears edge");

    // R9 new edge in the same cycle as ack
    tick(2);
    irq_in[6] = 1'b1;
    tick(1);
    irq_in[6] = 1'b0;
    tick(4);
    expect_item(0, 32'h40, 32'h40, "R9 preset");
    irq_in[6] = 1'b1;
    tick(2);
    ack(6);
    expect_item(0, 32'h40, 32'h40, "R9 edge beats ack");
    ack(6);
    expect_item(0, 32'h40, 32'h0, "R8 later ack clears");

    // R10 and R3 falling edge on external source 21
    irq_in[21] = 1'b1;
    tick(4);
    expect_item(0, 32'h0020_0000, 32'h0020_0000, "R2 level before reconfig");
    cfg(21, 2'b11);
    expect_item(0, 32'h0020_0000, 32'h0, "R10 write clears");
    tick(2);
    expect_item(0, 32'h0020_0000, 32'h0, "R10 no false edge");
    irq_in[21] = 1'b0;
    tick(4);
    expect_item(0, 32'h0020_0000, 32'h0020_0000, "R3 falling edge");
    irq_in[21] = 1'b1;
    tick(4);
    expect_item(0, 32'h0020_0000, 32'h0020_0000, "R3 rise ignored, still sticky");
    ack(21);
    expect_item(0, 32'h0020_0000, 32'h0, "R8 falling ack");

    // R6 internal source 9 with code 11 acts as rising edge
    cfg(9, 2'b11);
    irq_in[9] = 1'b1;
    tick(4);
    expect_item(0, 32'h200, 32'h200, "R6 internal rising");
    ack(9);
    irq_in[9] = 1'b0;
    tick(4);
    expect_item(0, 32'h200, 32'h0, "R6 internal no falling");

    tick(2);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule